// File: doc/BRIEF.md
# Timer Overflow and Compare Flag Unit

This block is an 8-bit timer/counter that keeps two interrupt flags, overflow and compare-match. Each flag has its own request line to an interrupt controller. The counter advances on every clock and has two modes:

- **Normal mode:** a plain up-counter that wraps from all ones to zero.
- **PWM mode:** a triangle counter. It climbs to all ones, then descends to zero, then climbs again.

A compare value is matched against the count on every cycle.

Each flag is set by hardware and cleared in one of two ways:

- Software writes a one into its bit position on the flag-write port.
- The interrupt controller pulses the acknowledge line for that flag when it takes the vector.

A request is raised while three things are all one: the flag, its own enable and a global enable.

Top module: `tmr8_flag_unit`

## Requirements
- R1: While `rst_n` is low and after its release, the count, both flags and both requests are zero until the first counting edge.
- R2: In normal mode (`mode_pwm`=0) the count rises by one on every clock edge. It wraps from 0xFF to 0x00.
- R3: In normal mode the overflow flag is set on the edge where the count goes from 0xFF to 0x00, so it reads one in the cycle where the count is 0x00.
- R4: In PWM mode (`mode_pwm`=1) the count climbs to 0xFF, then steps down to 0x00, then climbs again. Each end value lasts exactly one cycle.
- R5: In PWM mode the overflow flag is set only on the edge where the count turns upward from 0x00 after descending. It is not set at 0xFF.
- R6: The compare flag is set on the edge after a cycle in which the count equals `cmp_val`. This holds in either mode and either direction.
- R7: A cycle with `flag_wr`=1 clears each flag whose bit in `flag_wdata` is one (bit 0 overflow, bit 1 compare). Zero bits leave their flag as it was.
- R8: `ovf_ack` clears only the overflow flag, and `cmp_ack` clears only the compare flag.
- R9: When a hardware set and a clear fall on the same edge, the flag ends up set.
- R10: `ovf_irq` is one exactly when `gie`, `ovf_ie` and the overflow flag are all one.
- R11: `cmp_irq` is one exactly when `gie`, `cmp_ie` and the compare flag are all one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pwm | input | 1 | 0 selects normal wrap counting, 1 selects up/down counting |
| cmp_val | input | 8 | Compare value |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Write-one-to-clear data: bit 0 overflow, bit 1 compare |
| ovf_ack | input | 1 | Overflow vector acknowledge, clears the overflow flag |
| cmp_ack | input | 1 | Compare vector acknowledge, clears the compare flag |
| gie | input | 1 | Global interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
A hardware set of a flag can land on the same edge as a clear of that flag, from either a software write or a vector acknowledge. The bench provokes this on purpose. It drives a write of one and an acknowledge in the cycle where the count equals the compare value. It does the same in the cycle where the count sits at 0xFF in normal mode. It also does so at random whenever its model sees a match pending. Every cycle it compares the flag against a model that gives the set priority, so a flag reading zero after such a collision is reported as a failure.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } tmr_dir_e;

   localparam int FLG_OVF = 0;
   localparam int FLG_CMP = 1;
   localparam int NUM_FLG = 2;

endpackage

// File: rtl/tmr8_count_core.sv
module tmr8_count_core
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_pwm,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap_evt
);

   localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] BOT_VAL = '0;
   localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

   tmr_dir_e         dir_q;
   tmr_dir_e         dir_nxt;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt  = cnt_q + ONE_VAL;
      dir_nxt  = DIR_UP;
      wrap_evt = 1'b0;
      if (!mode_pwm) begin
         wrap_evt = (cnt_q == TOP_VAL);
      end else begin
         unique case (dir_q)
            DIR_UP: begin
               if (cnt_q == TOP_VAL) begin
                  cnt_nxt = cnt_q - ONE_VAL;
                  dir_nxt = DIR_DOWN;
               end
            end
            DIR_DOWN: begin
               if (cnt_q == BOT_VAL) begin
                  wrap_evt = 1'b1;
               end else begin
                  cnt_nxt = cnt_q - ONE_VAL;
                  dir_nxt = DIR_DOWN;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= DIR_UP;
      end else begin
         cnt_q <= cnt_nxt;
         dir_q <= dir_nxt;
      end
   end

endmodule

// File: rtl/tmr8_flag_cell.sv
module tmr8_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
   end

endmodule

// File: rtl/tmr8_irq_gate.sv
module tmr8_irq_gate #(
   parameter int N = 2
) (
   input  logic         glb_en,
   input  logic [N-1:0] src_en,
   input  logic [N-1:0] src_flag,
   output logic [N-1:0] req
);

   for (genvar g = 0; g < N; g++) begin : g_req
      assign req[g] = glb_en & src_en[g] & src_flag[g];
   end

endmodule

// File: rtl/tmr8_flag_unit.sv
module tmr8_flag_unit
   import tmr8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_pwm,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             flag_wr,
   input  logic [1:0]       flag_wdata,
   input  logic             ovf_ack,
   input  logic             cmp_ack,
   input  logic             gie,
   input  logic             ovf_ie,
   input  logic             cmp_ie,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             cmp_flag,
   output logic             ovf_irq,
   output logic             cmp_irq
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tmr8_flag_unit: CNT_W must be at least 2");
   end

   logic               wrap_evt;
   logic [NUM_FLG-1:0] set_vec;
   logic [NUM_FLG-1:0] clr_vec;
   logic [NUM_FLG-1:0] ack_vec;
   logic [NUM_FLG-1:0] en_vec;
   logic [NUM_FLG-1:0] flag_vec;
   logic [NUM_FLG-1:0] req_vec;

   tmr8_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_pwm (mode_pwm),
      .cnt_q    (count),
      .wrap_evt (wrap_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[FLG_OVF] = wrap_evt;
      set_vec[FLG_CMP] = (count == cmp_val);
      ack_vec          = '0;
      ack_vec[FLG_OVF] = ovf_ack;
      ack_vec[FLG_CMP] = cmp_ack;
      en_vec           = '0;
      en_vec[FLG_OVF]  = ovf_ie;
      en_vec[FLG_CMP]  = cmp_ie;
      clr_vec          = ack_vec | ({NUM_FLG{flag_wr}} & flag_wdata);
   end

   for (genvar f = 0; f < NUM_FLG; f++) begin : g_flag
      tmr8_flag_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_evt (set_vec[f]),
         .clr_req (clr_vec[f]),
         .flag_q  (flag_vec[f])
      );
   end

   tmr8_irq_gate #(.N(NUM_FLG)) u_irq (
      .glb_en   (gie),
      .src_en   (en_vec),
      .src_flag (flag_vec),
      .req      (req_vec)
   );

   assign ovf_flag = flag_vec[FLG_OVF];
   assign cmp_flag = flag_vec[FLG_CMP];
   assign ovf_irq  = req_vec[FLG_OVF];
   assign cmp_irq  = req_vec[FLG_CMP];

endmodule

// File: rtl/tmr8_flag_unit_chk.sv
module tmr8_flag_unit_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_pwm,
   input logic [CNT_W-1:0] cmp_val,
   input logic             flag_wr,
   input logic [1:0]       flag_wdata,
   input logic             ovf_ack,
   input logic             cmp_ack,
   input logic             gie,
   input logic             ovf_ie,
   input logic             cmp_ie,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             cmp_flag,
   input logic             ovf_irq,
   input logic             cmp_irq
);

   localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

   always_comb begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (count == '0 && !ovf_flag && !cmp_flag);
      end
   end

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_pwm |=> count == CNT_W'($past(count) + ONE_VAL));

   assert_wrap_sets_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_pwm && count == TOP_VAL) |=> ovf_flag);

   assert_turn_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pwm && count == TOP_VAL) |=> count == TOP_VAL - ONE_VAL);

   assert_turn_at_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_pwm && $past(mode_pwm) && count == '0 && $past(count) == ONE_VAL) |=> ovf_flag);

   assert_match_sets_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (count == cmp_val) |=> cmp_flag);

   assert_write_clears_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && flag_wdata[1] && count != cmp_val) |=> !cmp_flag);

   assert_ack_clears_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_ack && count != cmp_val) |=> !cmp_flag);

   assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (count == cmp_val && cmp_ack && flag_wr && flag_wdata[1]) |=> cmp_flag);

   assert_ovf_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (gie && ovf_ie && ovf_flag));

   assert_cmp_req_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_irq |-> (gie && cmp_ie && cmp_flag));

endmodule

bind tmr8_flag_unit tmr8_flag_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_pwm   (mode_pwm),
   .cmp_val    (cmp_val),
   .flag_wr    (flag_wr),
   .flag_wdata (flag_wdata),
   .ovf_ack    (ovf_ack),
   .cmp_ack    (cmp_ack),
   .gie        (gie),
   .ovf_ie     (ovf_ie),
   .cmp_ie     (cmp_ie),
   .count      (count),
   .ovf_flag   (ovf_flag),
   .cmp_flag   (cmp_flag),
   .ovf_irq    (ovf_irq),
   .cmp_irq    (cmp_irq)
);

// File: tb/sim_tmr8_flag_unit.sv
module sim_tmr8_flag_unit;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       mode_pwm;
   logic [7:0] cmp_val;
   logic       flag_wr;
   logic [1:0] flag_wdata;
   logic       ovf_ack;
   logic       cmp_ack;
   logic       gie;
   logic       ovf_ie;
   logic       cmp_ie;
   logic [7:0] count;
   logic       ovf_flag;
   logic       cmp_flag;
   logic       ovf_irq;
   logic       cmp_irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // reference state
   logic [7:0] m_cnt;
   logic       m_down;
   logic       m_ovf;
   logic       m_cmp;
   string      t_cnt, t_ovf, t_cmp;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr8_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .mode_pwm(mode_pwm), .cmp_val(cmp_val),
      .flag_wr(flag_wr), .flag_wdata(flag_wdata), .ovf_ack(ovf_ack),
      .cmp_ack(cmp_ack), .gie(gie), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie),
      .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
      .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string clr_tag(input bit set, input bit wr_clr, input bit ack_clr,
                                     input string set_tag);
      if (set && (wr_clr || ack_clr)) return "R9";
      if (set) return set_tag;
      if (ack_clr && !wr_clr) return "R8";
      if (wr_clr) return "R7";
      return set_tag;
   endfunction

   // compare at the current negedge, apply new inputs, advance the model over the coming edge
   task automatic step(input logic pwm, input logic [7:0] cv, input logic wr,
                       input logic [1:0] wd, input logic oa, input logic ca,
                       input logic g, input logic oie, input logic cie);
      bit ev_ovf, ev_cmp;
      chk(count == m_cnt, t_cnt, count, m_cnt);
      chk(ovf_flag == m_ovf, t_ovf, ovf_flag, m_ovf);
      chk(cmp_flag == m_cmp, t_cmp, cmp_flag, m_cmp);
      chk(ovf_irq == (gie & ovf_ie & m_ovf), "R10", ovf_irq, gie & ovf_ie & m_ovf);
      chk(cmp_irq == (gie & cmp_ie & m_cmp), "R11", cmp_irq, gie & cmp_ie & m_cmp);
      mode_pwm = pwm; cmp_val = cv; flag_wr = wr; flag_wdata = wd;
      ovf_ack = oa; cmp_ack = ca; gie = g; ovf_ie = oie; cmp_ie = cie;
      ev_ovf = pwm ? (m_down && m_cnt == 8'h00) : (m_cnt == 8'hFF);
      ev_cmp = (m_cnt == cv);
      t_ovf = clr_tag(ev_ovf, wr & wd[0], oa, pwm ? "R5" : "R3");
      t_cmp = clr_tag(ev_cmp, wr & wd[1], ca, "R6");
      if (ev_ovf) m_ovf = 1'b1; else if ((wr & wd[0]) | oa) m_ovf = 1'b0;
      if (ev_cmp) m_cmp = 1'b1; else if ((wr & wd[1]) | ca) m_cmp = 1'b0;
      t_cnt = pwm ? "R4" : "R2";
      if (!pwm) begin
         m_cnt = m_cnt + 8'd1; m_down = 1'b0;
      end else if (!m_down) begin
         if (m_cnt == 8'hFF) begin m_cnt = 8'hFE; m_down = 1'b1; end
         else m_cnt = m_cnt + 8'd1;
      end else begin
         if (m_cnt == 8'h00) begin m_cnt = 8'h01; m_down = 1'b0; end
         else m_cnt = m_cnt - 8'd1;
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic       r_pwm, r_wr, r_oa, r_ca, r_g, r_oie, r_cie;
      logic [7:0] r_cv;
      logic [1:0] r_wd;
      void'($urandom(32'd4242));
      rst_n = 1'b0; mode_pwm = 1'b0; cmp_val = 8'h10; flag_wr = 1'b0; flag_wdata = 2'b00;
      ovf_ack = 1'b0; cmp_ack = 1'b0; gie = 1'b1; ovf_ie = 1'b1; cmp_ie = 1'b1;
      m_cnt = 8'h00; m_down = 1'b0; m_ovf = 1'b0; m_cmp = 1'b0;
      t_cnt = "R1"; t_ovf = "R1"; t_cmp = "R1";
      repeat (3) @(negedge clk);
      // R1: reset state with every enable high
      chk(count == 8'h00, "R1", count, 0);
      chk(!ovf_flag && !cmp_flag, "R1", {ovf_flag, cmp_flag}, 0);
      chk(!ovf_irq && !cmp_irq, "R1", {ovf_irq, cmp_irq}, 0);
      rst_n = 1'b1;

      // normal mode, plain run through two wraps (R2, R3, R6)
      for (int i = 0; i < 520; i++) step(1'b0, 8'hFF, 0, 2'b00, 0, 0, 1, 1, 1);
      // write-zero must not clear (R7), then write-one clears both
      step(1'b0, 8'h80, 1, 2'b00, 0, 0, 1, 1, 1);
      step(1'b0, 8'h80, 1, 2'b11, 0, 0, 1, 1, 1);
      // collision: clear while count equals compare value and at 0xFF (R9)
      while (m_cnt != 8'h40) step(1'b0, 8'h40, 0, 2'b00, 0, 0, 1, 1, 1);
      step(1'b0, 8'h40, 1, 2'b10, 0, 1, 1, 1, 1);
      while (m_cnt != 8'hFF) step(1'b0, 8'h40, 0, 2'b00, 0, 0, 1, 0, 1);
      step(1'b0, 8'h40, 1, 2'b01, 1, 0, 1, 1, 1);
      // acks clear only their own flag (R8)
      step(1'b0, 8'h40, 0, 2'b00, 1, 0, 1, 1, 1);
      step(1'b0, 8'h40, 0, 2'b00, 0, 1, 0, 1, 1);
      // PWM mode sweeps with compare at both ends (R4, R5, R6)
      for (int i = 0; i < 1100; i++) step(1'b1, (i < 550) ? 8'h00 : 8'hFF, 0, 2'b00, 0, 0, 1, 1, 1);
      step(1'b1, 8'h20, 1, 2'b11, 0, 0, 1, 1, 1);

      // constrained random
      r_pwm = 1'b0; r_cv = 8'h33; r_g = 1'b1; r_oie = 1'b1; r_cie = 1'b1;
      for (int i = 0; i < 30000; i++) begin
         if ($urandom_range(0, 1999) == 0) r_pwm = ~r_pwm;
         if ($urandom_range(0, 299) == 0) begin
            case ($urandom_range(0, 3))
               0: r_cv = 8'h00;
               1: r_cv = 8'hFF;
               default: r_cv = 8'($urandom);
            endcase
         end
         if ($urandom_range(0, 49) == 0) r_g = ~r_g;
         if ($urandom_range(0, 49) == 0) r_oie = ~r_oie;
         if ($urandom_range(0, 49) == 0) r_cie = ~r_cie;
         r_wr = ($urandom_range(0, 7) == 0);
         r_wd = 2'($urandom);
         r_oa = ($urandom_range(0, 9) == 0);
         r_ca = ($urandom_range(0, 9) == 0);
         if (m_cnt == r_cv && $urandom_range(0, 1) == 0) begin
            r_wr = 1'b1; r_wd = 2'b11; r_ca = 1'b1;
         end
         step(r_pwm, r_cv, r_wr, r_wd, r_oa, r_ca, r_g, r_oie, r_cie);
      end
      step(1'b0, 8'h00, 0, 2'b00, 0, 0, 1, 1, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule